// File: doc/BRIEF.md
# Condition Flag Generator with Optional Parity and Half-Carry

This block forms the condition flags for a 64-bit or 32-bit integer add/subtract datapath. It takes two operands, an operation select (add or subtract) and a width select, computes the result internally, and derives four condition flags: negative, zero, carry and signed overflow. The flags are captured into a 32-bit flags register, but only when a set-flags strobe is high. Otherwise the register keeps its previous contents.

A compatibility mode is controlled by a single enable input. When it is high, the block also computes two legacy flags. The first is an even-parity flag over the low result byte, formed by a balanced XOR tree. The second is a nibble half-carry flag for decimal arithmetic. Both go into two bit positions that otherwise always read as zero. When the enable is low, the block behaves as a plain four-flag unit.

Top module: `flagx_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, flags_q is all zeros.
- R2: When set_flags is low at a rising clock edge, flags_q keeps its value regardless of any other input.
- R3: Bit 31 (N) is the most significant bit of the result at the selected width: bit 63 when wide_sel=1, bit 31 when wide_sel=0. N and Z are never both set.
- R4: Bit 30 (Z) is 1 exactly when every bit of the selected-width result is zero.
- R5: Bit 29 (C) is the carry out of the selected width for add (sub_op=0). For subtract (sub_op=1) it is 1 when no borrow occurs, that is, when op_a >= op_b unsigned at the selected width.
- R6: Bit 28 (V) is 1 when two's-complement overflow occurs. For add, this means equal operand signs and a result sign that differs from them. For subtract, it means differing operand signs and a result sign that differs from op_a.
- R7: With ext_en=1, bit 26 (parity) is 1 when result bits [7:0] contain an even number of ones.
- R8: With ext_en=1, bit 27 (half-carry) is the carry out of bit 3 for add, and the borrow into bit 3 (op_a[3:0] < op_b[3:0]) for subtract.
- R9: With ext_en=0 at the strobe, bits 27 and 26 are zero. Bits 25 to 0 are always zero.
- R10: When wide_sel=0, operand bits 63 to 32 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | First operand (minuend for subtract) |
| op_b | input | 64 | Second operand (subtrahend for subtract) |
| wide_sel | input | 1 | 1 selects 64-bit width, 0 selects 32-bit width |
| sub_op | input | 1 | 0 selects add, 1 selects subtract |
| set_flags | input | 1 | Capture the new flags at this edge |
| ext_en | input | 1 | Enable the parity and half-carry flags |
| flags_q | output | 32 | Registered flags word |

## Verification
The properties assume that reset is applied synchronously for at least one edge. They also assume that every input is stable across the capturing edge, because each flag is compared one cycle later against the internal result sampled at that edge. The bench changes inputs only on falling edges and holds them for a full cycle before it checks, so this assumption always holds. Reset is asserted both at time zero and again in the middle of the run, each time on a falling edge.

// File: rtl/flagx_pkg.sv
package flagx_pkg;
  localparam int FLAGS_W  = 32;
  localparam int NIB_W    = 4;
  localparam int POS_N    = 31;
  localparam int POS_Z    = 30;
  localparam int POS_C    = 29;
  localparam int POS_V    = 28;
  localparam int POS_AUX  = 27;
  localparam int POS_PAR  = 26;

  // carry out of a 4-bit slice: a + b + cin
  function automatic logic f_nib_carry(input logic [NIB_W-1:0] a,
                                       input logic [NIB_W-1:0] b,
                                       input logic cin);
    logic [NIB_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
    return s[NIB_W];
  endfunction

  // signed overflow from the signs seen by the adder (b already inverted for subtract)
  function automatic logic f_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/flagx_adder.sv
module flagx_adder #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              nib_cout_o,
  output logic              sa_o,
  output logic              sb_o,
  output logic              sr_o
);
  import flagx_pkg::*;
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   b_eff;
  logic [DATA_W:0]     sum_w;
  logic [NARROW_W:0]   sum_n;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_w = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    sum_n = {1'b0, a_i[NARROW_W-1:0]} + {1'b0, b_eff[NARROW_W-1:0]}
          + {{NARROW_W{1'b0}}, sub_i};
    if (wide_i) begin
      res_o  = sum_w[DATA_W-1:0];
      cout_o = sum_w[DATA_W];
      sa_o   = a_i[DATA_W-1];
      sb_o   = b_eff[DATA_W-1];
      sr_o   = sum_w[DATA_W-1];
    end else begin
      res_o  = {{PAD_W{1'b0}}, sum_n[NARROW_W-1:0]};
      cout_o = sum_n[NARROW_W];
      sa_o   = a_i[NARROW_W-1];
      sb_o   = b_eff[NARROW_W-1];
      sr_o   = sum_n[NARROW_W-1];
    end
    nib_cout_o = f_nib_carry(a_i[NIB_W-1:0], b_eff[NIB_W-1:0], sub_i);
  end
endmodule

// File: rtl/flagx_parity.sv
module flagx_parity #(
  parameter int PAR_BITS = 8
) (
  input  logic [PAR_BITS-1:0] bits_i,
  output logic                even_o
);
  localparam int NODES = 2 * PAR_BITS - 1;
  logic [NODES-1:0] node;

  // heap-ordered tree: leaves occupy the upper half, inner node i = children 2i+1, 2i+2
  genvar g;
  generate
    for (g = 0; g < PAR_BITS; g++) begin : g_leaf
      assign node[PAR_BITS-1+g] = bits_i[g];
    end
    for (g = 0; g < PAR_BITS-1; g++) begin : g_inner
      assign node[g] = node[2*g+1] ^ node[2*g+2];
    end
  endgenerate

  assign even_o = ~node[0];
endmodule

// File: rtl/flagx_pack.sv
module flagx_pack #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]           res_i,
  input  logic                        cout_i,
  input  logic                        nib_cout_i,
  input  logic                        sa_i,
  input  logic                        sb_i,
  input  logic                        sr_i,
  input  logic                        sub_i,
  input  logic                        par_even_i,
  input  logic                        ext_i,
  output logic [flagx_pkg::FLAGS_W-1:0] flags_o
);
  import flagx_pkg::*;
  always_comb begin
    flags_o          = '0;
    flags_o[POS_N]   = sr_i;
    flags_o[POS_Z]   = ~|res_i;
    flags_o[POS_C]   = cout_i;
    flags_o[POS_V]   = f_ovf(sa_i, sb_i, sr_i);
    flags_o[POS_AUX] = ext_i & (sub_i ? ~nib_cout_i : nib_cout_i);
    flags_o[POS_PAR] = ext_i & par_even_i;
  end
endmodule

// File: rtl/flagx_unit.sv
module flagx_unit #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int PAR_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    op_a,
  input  logic [DATA_W-1:0]    op_b,
  input  logic                 wide_sel,
  input  logic                 sub_op,
  input  logic                 set_flags,
  input  logic                 ext_en,
  output logic [flagx_pkg::FLAGS_W-1:0] flags_q
);
  import flagx_pkg::*;

  logic [DATA_W-1:0]  res_w;
  logic               cout_w, nib_cout_w, sa_w, sb_w, sr_w, par_even_w;
  logic [FLAGS_W-1:0] flags_d;

  flagx_adder #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_add (
    .a_i(op_a), .b_i(op_b), .sub_i(sub_op), .wide_i(wide_sel),
    .res_o(res_w), .cout_o(cout_w), .nib_cout_o(nib_cout_w),
    .sa_o(sa_w), .sb_o(sb_w), .sr_o(sr_w));

  flagx_parity #(.PAR_BITS(PAR_BITS)) u_par (
    .bits_i(res_w[PAR_BITS-1:0]), .even_o(par_even_w));

  flagx_pack #(.DATA_W(DATA_W)) u_pack (
    .res_i(res_w), .cout_i(cout_w), .nib_cout_i(nib_cout_w),
    .sa_i(sa_w), .sb_i(sb_w), .sr_i(sr_w), .sub_i(sub_op),
    .par_even_i(par_even_w), .ext_i(ext_en), .flags_o(flags_d));

  always_ff @(posedge clk) begin
    if (!rst_n)         flags_q <= '0;
    else if (set_flags) flags_q <= flags_d;
  end
endmodule

// File: rtl/flagx_chk.sv
module flagx_chk #(
  parameter int DATA_W   = 64,
  parameter int PAR_BITS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_flags,
  input logic              ext_en,
  input logic [DATA_W-1:0] res_w,
  input logic [31:0]       flags_q
);
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags_q)); // R2
  AST_N_Z_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q[31] && flags_q[30])); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q[30] == ($past(res_w) == '0)); // R4
  AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && ext_en) |=> flags_q[26] == ~(^$past(res_w[PAR_BITS-1:0]))); // R7
  AST_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !ext_en) |=> flags_q[27:26] == 2'b00); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[25:0] == '0); // R9
endmodule

bind flagx_unit flagx_chk #(.DATA_W(DATA_W), .PAR_BITS(PAR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_flags(set_flags), .ext_en(ext_en),
  .res_w(res_w), .flags_q(flags_q));

// File: tb/flagx_unit_tb.sv
`timescale 1ns/1ps
module flagx_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic        wide_sel, sub_op, set_flags, ext_en;
  logic [31:0] flags_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flagx_unit u_dut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .wide_sel(wide_sel), .sub_op(sub_op), .set_flags(set_flags),
    .ext_en(ext_en), .flags_q(flags_q));

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        wide;
    logic        sub;
    logic        ext;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{64'h1, 64'h1, 1'b1, 1'b0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 1'b0, 1'b1},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 1'b0, 1'b1},
    '{64'h5, 64'h5, 1'b1, 1'b1, 1'b1},
    '{64'h3, 64'h5, 1'b1, 1'b1, 1'b1},
    '{64'h8000_0000_0000_0000, 64'h1, 1'b1, 1'b1, 1'b1},
    '{64'hDEAD_BEEF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 1'b1},
    '{64'h0000_0000_7FFF_FFFF, 64'h1, 1'b0, 1'b0, 1'b1},
    '{64'h0, 64'h1, 1'b0, 1'b1, 1'b1},
    '{64'h0F, 64'h01, 1'b1, 1'b0, 1'b0},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b1, 1'b0, 1'b1},
    '{64'h0000_0000_8000_0010, 64'h0000_0000_0000_0021, 1'b0, 1'b1, 1'b1}
  };

  // independent model written from the requirements
  function automatic logic [31:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic wide, input logic sub, input logic ext);
    logic [64:0] s; logic [63:0] r, am, bm; int msb; logic sa, sb2, sr;
    logic [31:0] f;
    msb = wide ? 63 : 31;
    am = wide ? a : {32'b0, a[31:0]};
    bm = wide ? b : {32'b0, b[31:0]};
    f = '0;
    if (sub) r = am - bm; else r = am + bm;
    if (!wide) r = {32'b0, r[31:0]};
    sa = am[msb]; sb2 = bm[msb]; sr = r[msb];
    f[31] = sr;
    f[30] = (r == 64'b0);
    if (sub) f[29] = (am >= bm);
    else begin s = {1'b0, am} + {1'b0, bm}; f[29] = wide ? s[64] : s[32]; end
    f[28] = sub ? ((sa != sb2) && (sr != sa)) : ((sa == sb2) && (sr != sa));
    if (ext) begin
      f[27] = sub ? (a[3:0] < b[3:0]) : ((5'(a[3:0]) + 5'(b[3:0])) > 5'd15);
      f[26] = ~(^r[7:0]);
    end
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (flags_q !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, flags_q, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic w,
                       input logic s, input logic e, input logic strobe);
    @(negedge clk);
    op_a = a; op_b = b; wide_sel = w; sub_op = s; ext_en = e; set_flags = strobe;
    @(negedge clk);
    set_flags = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    rst_n = 1'b0; op_a = '0; op_b = '0; wide_sel = 1'b1; sub_op = 1'b0;
    set_flags = 1'b0; ext_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'h0);

    // table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].wide, VECS[i].sub, VECS[i].ext, 1'b1);
      check($sformatf("R3-vector %0d (N Z C V PF AF)", i),
            model(VECS[i].a, VECS[i].b, VECS[i].wide, VECS[i].sub, VECS[i].ext));
    end

    // R4 R5 directed: 64-bit all ones plus one -> Z, C, AF, PF
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R4 R5 R8 wrap", 32'h6C00_0000);

    // R6: min signed minus one overflows, no borrow
    apply(64'h8000_0000_0000_0000, 64'h1, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R6 sub overflow", 32'h3000_0000);

    // R8 subtract borrow from nibble: 0x10 - 0x01 = 0x0F, AF=1, parity even
    apply(64'h10, 64'h01, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R8 sub half borrow", 32'h2C00_0000);

    // R9: same stimulus, extension off
    apply(64'h10, 64'h01, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R9 ext off", 32'h2000_0000);

    // R10: upper operand bits ignored in narrow mode
    apply(64'hFFFF_0000_0000_0003, 64'h1234_5678_0000_0003, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R10 narrow upper ignored", 32'h6400_0000);

    // R2: hold without strobe
    snap = flags_q;
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R2 hold", snap);

    // R1: mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule